// File: doc/BRIEF.md
# Per-Port Output Frequency Selector

This block drives four output ports, each from its own 4-bit selection code. A code either turns the port off or picks one of several sources: a 2 kHz sync signal, an 8 kHz sync signal, one of two digital frequencies made elsewhere, the undivided T0 source clock, or an even division of either the T0 or the T4 source clock. A code value does not always mean the same thing on every port. Port 1 and port 4 each give a few codes their own meanings.

Both source clocks have a bank of even-ratio dividers inside the block. Each bank runs in its own clock domain, and every divider output has 50:50 duty. The sync and digital inputs come in as finished signals and pass straight to any port that selects them. The block does not switch glitch-free between asynchronous clocks. Instead, after a code change the port is held low for a short settling window, counted in the clock domain that governs the new selection, and then it follows the new source.

The selection codes are plain configuration pins. The block has no data stream, so it has no valid/ready handshake. All outputs are level signals.

Top module: `outclk_select`

## Requirements
- R1: The code for port 1 is `cfg_p14[7:4]`, for port 4 `cfg_p14[3:0]`, for port 2 `cfg_p23[7:4]` and for port 3 `cfg_p23[3:0]`; port N drives `port_o[N-1]`.
- R2: Code 0000 drives a constant 0 on any port.
- R3: On every port, code 0001 passes `sync_2k`, code 0010 passes `sync_8k` and code 0100 passes `dig_a`; on ports 2, 3 and 4, code 0011 passes `dig_b`.
- R4: On every port, codes 0110, 0111, 1000, 1001 and 1010 give T0 divided by 16, 12, 8, 6 and 4 respectively; on ports 2, 3 and 4, code 0101 gives T0 divided by 48.
- R5: On port 1, code 0011 gives T0 divided by 2, and code 0101 gives the undivided T0 clock.
- R6: Code 1100 gives T4/48, 1101 gives T4/16, 1110 gives T4/8 and 1111 gives T4/4 on every port; on ports 1 to 3, code 1011 gives T4/64.
- R7: On port 4, code 1011 gives T4 divided by 2.
- R8: A divide-by-N output is 0 during reset and changes level on every (N/2)-th rising edge of its source clock after reset release, so it rises first on edge N/2 and has 50:50 duty.
- R9: After reset release, or after any change of a port's code, that port drives 0 until the third rising edge of its governing clock (T4 for T4-divided codes, T0 for all others) that follows the change; from then on it follows the selected source.
- R10: While `rst_n` is low, every port drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_t0 | input | 1 | T0 source clock |
| clk_t4 | input | 1 | T4 source clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_p14 | input | 8 | Selection codes: port 1 in [7:4], port 4 in [3:0] |
| cfg_p23 | input | 8 | Selection codes: port 2 in [7:4], port 3 in [3:0] |
| sync_2k | input | 1 | Ready-made 2 kHz sync signal |
| sync_8k | input | 1 | Ready-made 8 kHz sync signal |
| dig_a | input | 1 | First digital frequency |
| dig_b | input | 1 | Second digital frequency |
| port_o | output | 4 | Port outputs, bit N-1 for port N |

## Verification
The hardest case to reach is a code that changes again while the settling window of a previous change is still open, particularly when the two codes belong to different clock domains. In that case one domain's guard has to restart while the other domain's guard is ignored. After a full sweep in which every port visits all sixteen codes, the stimulus goes into a phase that rewrites codes every one to three T0 cycles. That phase mixes T0, T4 and off codes and sometimes rewrites a code with the same value. The reference model tracks a settling count per port and per domain, so it predicts the low window exactly in every such case.

// File: rtl/outclk_select_pkg.sv
package outclk_select_pkg;

  localparam int N_PORTS   = 4;
  localparam int CODE_W    = 4;
  localparam int N_T0_TAPS = 7;
  localparam int N_T4_TAPS = 6;
  localparam int TAP_W     = 3;
  localparam int SETTLE    = 2;

  typedef enum logic [2:0] {
    K_OFF, K_S2K, K_S8K, K_DA, K_DB, K_T0RAW, K_T0DIV, K_T4DIV
  } src_kind_e;

  typedef struct packed {
    src_kind_e          kind;
    logic [TAP_W-1:0]   tap;
  } src_sel_t;

  // T0 tap order: 2,4,6,8,12,16,48
  function automatic int t0_ratio(input int i);
    case (i)
      0: return 2;
      1: return 4;
      2: return 6;
      3: return 8;
      4: return 12;
      5: return 16;
      default: return 48;
    endcase
  endfunction

  // T4 tap order: 2,4,8,16,48,64
  function automatic int t4_ratio(input int i);
    case (i)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 48;
      default: return 64;
    endcase
  endfunction

  function automatic src_sel_t mk(input src_kind_e k, input int t);
    src_sel_t s;
    s.kind = k;
    s.tap  = TAP_W'(t);
    return s;
  endfunction

  // port index 0..3 stands for ports 1..4
  function automatic src_sel_t decode(input int port, input logic [CODE_W-1:0] code);
    case (code)
      4'h0: return mk(K_OFF, 0);
      4'h1: return mk(K_S2K, 0);
      4'h2: return mk(K_S8K, 0);
      4'h3: return (port == 0) ? mk(K_T0DIV, 0) : mk(K_DB, 0);
      4'h4: return mk(K_DA, 0);
      4'h5: return (port == 0) ? mk(K_T0RAW, 0) : mk(K_T0DIV, 6);
      4'h6: return mk(K_T0DIV, 5);
      4'h7: return mk(K_T0DIV, 4);
      4'h8: return mk(K_T0DIV, 3);
      4'h9: return mk(K_T0DIV, 2);
      4'hA: return mk(K_T0DIV, 1);
      4'hB: return (port == 3) ? mk(K_T4DIV, 0) : mk(K_T4DIV, 5);
      4'hC: return mk(K_T4DIV, 4);
      4'hD: return mk(K_T4DIV, 3);
      4'hE: return mk(K_T4DIV, 2);
      default: return mk(K_T4DIV, 1);
    endcase
  endfunction

endpackage

// File: rtl/outclk_div.sv
module outclk_div #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic q_o
);
  localparam int HALF = RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      q_q   <= ~q_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;

  // R8
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (q_o != $past(q_o)));

  // R8
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(q_o));

endmodule

// File: rtl/outclk_hold.sv
module outclk_hold
  import outclk_select_pkg::*;
#(
  parameter int WAIT = SETTLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic              rdy_o
);
  localparam int CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] DONE = CW'(WAIT);

  logic [CODE_W-1:0] last_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else begin
      last_q <= code_i;
      if (last_q != code_i)  cnt_q <= '0;
      else if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rdy_o = (last_q == code_i) && (cnt_q == DONE);

  // R9
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q != code_i) |=> !rdy_o);

endmodule

// File: rtl/outclk_port.sv
module outclk_port
  import outclk_select_pkg::*;
#(
  parameter int PORT = 0
) (
  input  logic                 clk_t0,
  input  logic                 clk_t4,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code_i,
  input  logic [N_T0_TAPS-1:0] t0_tap_i,
  input  logic [N_T4_TAPS-1:0] t4_tap_i,
  input  logic                 sync_2k_i,
  input  logic                 sync_8k_i,
  input  logic                 dig_a_i,
  input  logic                 dig_b_i,
  output logic                 q_o
);
  src_sel_t sel;
  logic     rdy0, rdy4;
  logic     raw;
  logic     gate;

  assign sel = decode(PORT, code_i);

  outclk_hold i_hold_t0 (
    .clk(clk_t0), .rst_n(rst_n), .code_i(code_i), .rdy_o(rdy0)
  );

  outclk_hold i_hold_t4 (
    .clk(clk_t4), .rst_n(rst_n), .code_i(code_i), .rdy_o(rdy4)
  );

  always_comb begin
    raw = 1'b0;
    case (sel.kind)
      K_OFF:   raw = 1'b0;
      K_S2K:   raw = sync_2k_i;
      K_S8K:   raw = sync_8k_i;
      K_DA:    raw = dig_a_i;
      K_DB:    raw = dig_b_i;
      K_T0RAW: raw = clk_t0;
      K_T0DIV: raw = t0_tap_i[sel.tap];
      K_T4DIV: raw = t4_tap_i[sel.tap];
      default: raw = 1'b0;
    endcase
  end

  assign gate = (sel.kind == K_T4DIV) ? rdy4 : rdy0;
  assign q_o  = raw & gate;

  // R2
  off_quiet_chk: assert property (@(posedge clk_t0) disable iff (!rst_n)
    (code_i == '0) |-> !q_o);

  // R9
  t0_settle_chk: assert property (@(posedge clk_t0) disable iff (!rst_n)
    ((sel.kind != K_T4DIV) && !rdy0) |-> !q_o);

  // R9
  t4_settle_chk: assert property (@(posedge clk_t4) disable iff (!rst_n)
    ((sel.kind == K_T4DIV) && !rdy4) |-> !q_o);

  // R10
  always @(posedge clk_t0) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!q_o);
    end
  end

endmodule

// File: rtl/outclk_select.sv
module outclk_select
  import outclk_select_pkg::*;
(
  input  logic       clk_t0,
  input  logic       clk_t4,
  input  logic       rst_n,
  input  logic [7:0] cfg_p14,
  input  logic [7:0] cfg_p23,
  input  logic       sync_2k,
  input  logic       sync_8k,
  input  logic       dig_a,
  input  logic       dig_b,
  output logic [3:0] port_o
);
  logic [N_T0_TAPS-1:0] t0_tap;
  logic [N_T4_TAPS-1:0] t4_tap;
  logic [CODE_W-1:0]    code [N_PORTS];

  // R1: code field placement
  assign code[0] = cfg_p14[7:4];
  assign code[1] = cfg_p23[7:4];
  assign code[2] = cfg_p23[3:0];
  assign code[3] = cfg_p14[3:0];

  for (genvar i = 0; i < N_T0_TAPS; i++) begin : g_t0
    outclk_div #(.RATIO(t0_ratio(i))) i_div (
      .clk(clk_t0), .rst_n(rst_n), .q_o(t0_tap[i])
    );
  end

  for (genvar i = 0; i < N_T4_TAPS; i++) begin : g_t4
    outclk_div #(.RATIO(t4_ratio(i))) i_div (
      .clk(clk_t4), .rst_n(rst_n), .q_o(t4_tap[i])
    );
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    outclk_port #(.PORT(p)) i_port (
      .clk_t0    (clk_t0),
      .clk_t4    (clk_t4),
      .rst_n     (rst_n),
      .code_i    (code[p]),
      .t0_tap_i  (t0_tap),
      .t4_tap_i  (t4_tap),
      .sync_2k_i (sync_2k),
      .sync_8k_i (sync_8k),
      .dig_a_i   (dig_a),
      .dig_b_i   (dig_b),
      .q_o       (port_o[p])
    );
  end

endmodule

// File: tb/test_outclk_select.sv
module test_outclk_select;
  logic       clk_t0 = 1'b0;
  logic       clk_t4 = 1'b0;
  logic       rst_n  = 1'b0;
  logic [7:0] cfg_p14, cfg_p23;
  logic       sync_2k, sync_8k, dig_a, dig_b;
  logic [3:0] port_o;

  int vectors = 0;
  int fails   = 0;
  int k0 = 0, k4 = 0;
  int since0 [4];
  int since4 [4];
  logic [3:0] code [4];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  outclk_select i_outclk_select (
    .clk_t0(clk_t0), .clk_t4(clk_t4), .rst_n(rst_n),
    .cfg_p14(cfg_p14), .cfg_p23(cfg_p23),
    .sync_2k(sync_2k), .sync_8k(sync_8k), .dig_a(dig_a), .dig_b(dig_b),
    .port_o(port_o)
  );

  // 50 MHz T0; T4 at half rate, rising on every other T0 rising edge
  initial forever #10 clk_t0 = ~clk_t0;
  initial begin
    #10;
    forever begin
      clk_t4 = ~clk_t4;
      #20;
    end
  end

  // R1: packing of the four codes onto the two config bytes
  function automatic void pack();
    cfg_p14 = {code[0], code[3]};
    cfg_p23 = {code[1], code[2]};
  endfunction

  task automatic set_code(input int p, input logic [3:0] c);
    if (code[p] != c) begin
      since0[p] = 0;
      since4[p] = 0;
    end
    code[p] = c;
    pack();
  endtask

  // source id: -1 off, -2 2k, -3 8k, -4 dig_a, -5 dig_b, 1 raw T0,
  // N = T0/N, 100+N = T4/N
  function automatic int src_of(input int p, input logic [3:0] c);
    case (c)
      4'd0:  return -1;
      4'd1:  return -2;
      4'd2:  return -3;
      4'd3:  return (p == 0) ? 2 : -5;
      4'd4:  return -4;
      4'd5:  return (p == 0) ? 1 : 48;
      4'd6:  return 16;
      4'd7:  return 12;
      4'd8:  return 8;
      4'd9:  return 6;
      4'd10: return 4;
      4'd11: return (p == 3) ? 102 : 164;
      4'd12: return 148;
      4'd13: return 116;
      4'd14: return 108;
      default: return 104;
    endcase
  endfunction

  task automatic compare_all();
    for (int p = 0; p < 4; p++) begin
      int s;
      int sincec;
      logic ex;
      string tag;
      s = src_of(p, code[p]);
      sincec = (s > 100) ? since4[p] : since0[p];
      ex = 1'b0;
      tag = "R2";
      if (s == -1) begin
        ex = 1'b0; tag = "R2";
      end else if (sincec < 3) begin
        ex = 1'b0; tag = "R9";
      end else if (s == -2) begin
        ex = sync_2k; tag = "R3";
      end else if (s == -3) begin
        ex = sync_8k; tag = "R3";
      end else if (s == -4) begin
        ex = dig_a; tag = "R3";
      end else if (s == -5) begin
        ex = dig_b; tag = "R3";
      end else if (s == 1) begin
        ex = clk_t0; tag = "R5";
      end else if (s > 100) begin
        ex = logic'(((k4 / ((s - 100) / 2)) % 2) == 1);
        tag = (s == 102) ? "R7,R8" : "R6,R8";
      end else begin
        ex = logic'(((k0 / (s / 2)) % 2) == 1);
        tag = (p == 0 && s == 2) ? "R5,R8" : "R4,R8";
      end
      vectors++;
      if (port_o[p] !== ex) begin
        fails++;
        $display("FAIL %s R1 port%0d code=%b got=%b exp=%b t=%0t",
                 tag, p + 1, code[p], port_o[p], ex, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk_t0);
    #1;
    if (rst_n) begin
      k0++;
      for (int p = 0; p < 4; p++) since0[p]++;
      if (clk_t4) begin
        k4++;
        for (int p = 0; p < 4; p++) since4[p]++;
      end
    end
    @(negedge clk_t0);
    compare_all();
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sync_2k = lfsr[0];
    sync_8k = lfsr[3];
    dig_a   = lfsr[7];
    dig_b   = lfsr[11];
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    sync_2k = 1'b1; sync_8k = 1'b1; dig_a = 1'b1; dig_b = 1'b1;
    code[0] = 4'h5; code[1] = 4'h1; code[2] = 4'h4; code[3] = 4'hB;
    pack();
    for (int p = 0; p < 4; p++) begin
      since0[p] = 0;
      since4[p] = 0;
    end
    // R10: reset state, inputs high
    @(negedge clk_t0);
    vectors++;
    if (port_o !== 4'b0000) begin
      fails++;
      $display("FAIL R10 reset got=%b exp=0000", port_o);
    end
    #15 rst_n = 1'b1;
    // R9 window right after reset, then settle
    for (int i = 0; i < 40; i++) tick();

    // full sweep: each port visits every code (R2..R8)
    for (int step = 0; step < 16; step++) begin
      for (int p = 0; p < 4; p++) set_code(p, 4'((step + 5 * p) % 16));
      for (int i = 0; i < 150; i++) tick();
    end

    // rapid rewrites across domains, including same-value rewrites (R9)
    for (int i = 0; i < 400; i++) begin
      int p;
      p = i % 4;
      set_code(p, 4'((lfsr[7:4] ^ 4'(i)) & 4'hF));
      for (int j = 0; j < 1 + (i % 3); j++) tick();
    end

    // long run on the slowest dividers and port specials (R5, R7, R8)
    set_code(0, 4'hB);
    set_code(1, 4'h5);
    set_code(2, 4'hC);
    set_code(3, 4'hB);
    for (int i = 0; i < 400; i++) tick();
    set_code(0, 4'h3);
    set_code(3, 4'h0);
    for (int i = 0; i < 100; i++) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule